// File: doc/BRIEF.md
# Multi-mode latch banking unit

This unit translates CPU and PPU bus addresses for a console RAM cartridge that can behave like eight different discrete-logic mappers. A control register, written through a four-byte window near the top of the expansion I/O area, selects the banking mode, the nametable arrangement and whether program memory is protected. Its address lines and its data lines both carry fields. While program memory is protected, writes anywhere in the upper 32 KiB of CPU space load a bank latch. While it is unprotected, those writes go into program RAM instead.

The outputs are an 18-bit program address into 256 KiB, a 15-bit pattern address into 32 KiB, write enables for both memories, and the page that selects between the two internal nametables. All outputs are registered. Each one reflects the bus address that was presented in the previous cycle, translated with the state that held before any write in that cycle took effect.

Top module: `latch_bank_mapper`

## Requirements
- R1: After reset, program memory is protected, the mode equals the INIT_MODE parameter (default 1), the bank latch and the pattern bank are 0, and mirroring is vertical when INIT_VERT is 1 (default).
- R2: A CPU write whose address lies in $42FC-$42FF loads the control register. Address bit 1 is the protect flag (1 = protected). Data bits 7..5 form the mode. The mirroring code is {address bit 0, data bit 4}. Writes to any other address leave it unchanged.
- R3: A CPU write to $8000-$FFFF loads the bank latch only while protected. While unprotected, the write leaves the latch and pattern bank unchanged and raises prg_we one cycle later with prg_addr equal to the translation of that write's address. prg_we stays 0 for protected writes.
- R4: Mode 0 maps a 16 KiB bank from latch bits 2..0 at $8000-$BFFF and fixes 16 KiB bank 7 at $C000-$FFFF.
- R5: Mode 1 maps a 16 KiB bank from latch bits 6..2 at $8000-$BFFF, truncated to the 16 banks that exist, so bit 6 has no effect. It fixes bank 7 at $C000-$FFFF and takes the pattern bank from data bits 1..0.
- R6: Mode 2 maps latch bits 3..0 at $8000-$BFFF with bank 15 fixed at $C000-$FFFF. Mode 3 swaps the two halves.
- R7: Modes 4-7 map a 32 KiB bank: latch bits 5..4 in mode 4, bank 7 in mode 5, bank 3 in modes 6 and 7.
- R8: The pattern bank is loaded from data bits 1..0 in modes 1, 4 and 5, and from {0, data bit 0} in mode 6. In modes 0, 2, 3 and 7 it keeps its earlier value, including across mode changes. chr_addr is {pattern bank, PPU address bits 12..0}.
- R9: chr_we rises one cycle after a PPU write below $2000, and only in modes 0-3.
- R10: The nametable page is 0 for code 0, 1 for code 1, PPU address bit 10 for code 2 (vertical) and PPU address bit 11 for code 3 (horizontal).
- R11: Outputs lag the bus by one cycle. A latch write is translated with the old bank, and the new bank applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | PPU address |
| ppu_wr | input | 1 | PPU write strobe |
| prg_addr | output | 18 | Translated program memory address |
| prg_we | output | 1 | Program memory write enable |
| chr_addr | output | 15 | Translated pattern memory address |
| chr_we | output | 1 | Pattern memory write enable |
| nt_page | output | 1 | Internal nametable page select |

## Verification
A CPU write to the upper window is translated in the same cycle that it updates the bank latch. The translated address must use the bank that held before the write, and only the following access may see the new bank. The bench provokes this with a protected latch write that changes the bank. It compares prg_addr from the write cycle against the old bank and then re-reads the same address against the new one. It repeats the case unprotected, where the write must produce a program RAM strobe at the current mapping and leave the latch untouched.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef struct packed {
    logic       prot;
    mirror_e    mir;
    logic [2:0] mode;
  } ctrl_t;

  // modes that let PPU write to pattern memory
  function automatic logic chr_writable(input logic [2:0] mode);
    return (mode[2] == 1'b0);
  endfunction

endpackage

// File: rtl/lbm_mode_reg.sv
module lbm_mode_reg
  import lbm_pkg::*;
#(
  parameter logic [15:0] WIN_BASE  = 16'h42FC,
  parameter int          INIT_MODE = 1,
  parameter bit          INIT_VERT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  data,
  output ctrl_t       ctrl
);

  localparam logic [2:0] RST_MODE = 3'(INIT_MODE);
  localparam logic       RST_D4   = ~INIT_VERT;

  logic hit;
  assign hit = wr && (addr[15:2] == WIN_BASE[15:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.prot <= 1'b1;
      ctrl.mir  <= mirror_e'({1'b1, RST_D4});
      ctrl.mode <= RST_MODE;
    end else if (hit) begin
      ctrl.prot <= addr[1];
      ctrl.mir  <= mirror_e'({addr[0], data[4]});
      ctrl.mode <= data[7:5];
    end
  end

endmodule

// File: rtl/lbm_bank_latch.sv
module lbm_bank_latch
  import lbm_pkg::*;
#(
  parameter int CBW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [15:0]    addr,
  input  logic [7:0]     data,
  input  ctrl_t          ctrl,
  output logic [7:0]     latch,
  output logic [CBW-1:0] chr_bank
);

  logic           hit;
  logic [CBW-1:0] chr_next;

  assign hit = wr && addr[15] && ctrl.prot;

  always_comb begin
    chr_next = chr_bank;
    unique case (ctrl.mode)
      3'd1, 3'd4, 3'd5: chr_next = CBW'(data[1:0]);
      3'd6:             chr_next = CBW'(data[0]);
      default:          chr_next = chr_bank;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch    <= '0;
      chr_bank <= '0;
    end else if (hit) begin
      latch    <= data;
      chr_bank <= chr_next;
    end
  end

endmodule

// File: rtl/lbm_addr_map.sv
module lbm_addr_map
  import lbm_pkg::*;
#(
  parameter int PRG_AW = 18,
  parameter int CHR_AW = 15
) (
  input  ctrl_t                  ctrl,
  input  logic [7:0]             latch,
  input  logic [CHR_AW-14:0]     chr_bank,
  input  logic [15:0]            cpu_addr,
  input  logic [13:0]            ppu_addr,
  output logic [PRG_AW-1:0]      prg_addr,
  output logic [CHR_AW-1:0]      chr_addr,
  output logic                   nt_page
);

  localparam int B16W = PRG_AW - 14;
  localparam int B32W = PRG_AW - 15;

  logic [7:0] bank16;
  logic [7:0] bank32;
  logic       wide;

  always_comb begin
    bank16 = 8'd0;
    bank32 = 8'd0;
    wide   = 1'b0;
    unique case (ctrl.mode)
      3'd0: bank16 = cpu_addr[14] ? 8'd7  : {5'd0, latch[2:0]};
      3'd1: bank16 = cpu_addr[14] ? 8'd7  : {3'd0, latch[6:2]};
      3'd2: bank16 = cpu_addr[14] ? 8'd15 : {4'd0, latch[3:0]};
      3'd3: bank16 = cpu_addr[14] ? {4'd0, latch[3:0]} : 8'd15;
      3'd4: begin wide = 1'b1; bank32 = {6'd0, latch[5:4]}; end
      3'd5: begin wide = 1'b1; bank32 = 8'd7; end
      default: begin wide = 1'b1; bank32 = 8'd3; end
    endcase
  end

  always_comb begin
    if (wide) prg_addr = {bank32[B32W-1:0], cpu_addr[14:0]};
    else      prg_addr = {bank16[B16W-1:0], cpu_addr[13:0]};
  end

  assign chr_addr = {chr_bank, ppu_addr[12:0]};

  always_comb begin
    unique case (ctrl.mir)
      MIR_ONE_LO: nt_page = 1'b0;
      MIR_ONE_HI: nt_page = 1'b1;
      MIR_VERT:   nt_page = ppu_addr[10];
      default:    nt_page = ppu_addr[11];
    endcase
  end

endmodule

// File: rtl/latch_bank_mapper.sv
module latch_bank_mapper
  import lbm_pkg::*;
#(
  parameter int PRG_AW    = 18,
  parameter int CHR_AW    = 15,
  parameter int INIT_MODE = 1,
  parameter bit INIT_VERT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_wr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_we,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_we,
  output logic              nt_page
);

  localparam int CBW = CHR_AW - 13;

  ctrl_t             ctrl;
  logic [7:0]        latch;
  logic [CBW-1:0]    chr_bank;
  logic [PRG_AW-1:0] prg_addr_n;
  logic [CHR_AW-1:0] chr_addr_n;
  logic              nt_page_n;
  logic              prot;
  logic [2:0]        mode;

  assign prot = ctrl.prot;
  assign mode = ctrl.mode;

  lbm_mode_reg #(
    .WIN_BASE  (16'h42FC),
    .INIT_MODE (INIT_MODE),
    .INIT_VERT (INIT_VERT)
  ) u_mode (
    .clk  (clk),
    .rst  (rst),
    .wr   (cpu_wr),
    .addr (cpu_addr),
    .data (cpu_data),
    .ctrl (ctrl)
  );

  lbm_bank_latch #(.CBW(CBW)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .wr       (cpu_wr),
    .addr     (cpu_addr),
    .data     (cpu_data),
    .ctrl     (ctrl),
    .latch    (latch),
    .chr_bank (chr_bank)
  );

  lbm_addr_map #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_map (
    .ctrl     (ctrl),
    .latch    (latch),
    .chr_bank (chr_bank),
    .cpu_addr (cpu_addr),
    .ppu_addr (ppu_addr),
    .prg_addr (prg_addr_n),
    .chr_addr (chr_addr_n),
    .nt_page  (nt_page_n)
  );

  always_ff @(posedge clk) begin
    prg_addr <= prg_addr_n;
    chr_addr <= chr_addr_n;
    nt_page  <= nt_page_n;
    if (rst) begin
      prg_we <= 1'b0;
      chr_we <= 1'b0;
    end else begin
      prg_we <= cpu_wr && cpu_addr[15] && !prot;
      chr_we <= ppu_wr && !ppu_addr[13] && chr_writable(mode);
    end
  end

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int PRG_AW = 18,
  parameter int CBW    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_wr,
  input logic [13:0]       ppu_addr,
  input logic              ppu_wr,
  input logic              prot,
  input logic [2:0]        mode,
  input logic [7:0]        latch,
  input logic [CBW-1:0]    chr_bank,
  input logic [PRG_AW-1:0] prg_addr,
  input logic              prg_we,
  input logic              chr_we
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_PRG_WE_GATED: assert property (@(posedge clk) disable iff (rst || !armed)
    prg_we |-> $past(cpu_wr && cpu_addr[15] && !prot)); // R3

  AST_LATCH_IGNORED: assert property (@(posedge clk) disable iff (rst || !armed)
    (cpu_wr && cpu_addr[15] && !prot) |=> ($stable(latch) && $stable(chr_bank))); // R3

  AST_CHR_WE_MODES: assert property (@(posedge clk) disable iff (rst || !armed)
    chr_we |-> $past(ppu_wr && !ppu_addr[13] && mode < 3'd4)); // R9

  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(cpu_addr[15] && cpu_addr[14] && mode <= 3'd1)
      |-> prg_addr[PRG_AW-1:14] == (PRG_AW-14)'(7)); // R4

  AST_CHR_RETAIN: assert property (@(posedge clk) disable iff (rst || !armed)
    (cpu_wr && cpu_addr[15] &&
     (mode == 3'd0 || mode == 3'd2 || mode == 3'd3 || mode == 3'd7))
      |=> $stable(chr_bank)); // R8

endmodule

bind latch_bank_mapper lbm_checker #(.PRG_AW(PRG_AW), .CBW(CBW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .cpu_wr   (cpu_wr),
  .ppu_addr (ppu_addr),
  .ppu_wr   (ppu_wr),
  .prot     (prot),
  .mode     (mode),
  .latch    (latch),
  .chr_bank (chr_bank),
  .prg_addr (prg_addr),
  .prg_we   (prg_we),
  .chr_we   (chr_we)
);

// File: tb/tb_latch_bank_mapper.sv
module tb_latch_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_wr = 1'b0;
  logic [17:0] prg_addr;
  logic        prg_we;
  logic [14:0] chr_addr;
  logic        chr_we;
  logic        nt_page;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  latch_bank_mapper dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .prg_addr(prg_addr), .prg_we(prg_we), .chr_addr(chr_addr),
    .chr_we(chr_we), .nt_page(nt_page)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present a CPU access for one cycle; outputs sampled at the next falling edge
  task automatic cpu_op(input logic [15:0] a, input logic [7:0] d, input logic w);
    cpu_addr = a; cpu_data = d; cpu_wr = w;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic ppu_op(input logic [13:0] a, input logic w);
    ppu_addr = a; ppu_wr = w;
    @(negedge clk);
    ppu_wr = 1'b0;
  endtask

  task automatic t_reset;
    cpu_op(16'hC000, 8'h00, 1'b0); check("R1 fixed top after reset", prg_addr, 32'h1C000);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R1 latch zero after reset", prg_addr, 32'h00000);
    ppu_op(14'h2400, 1'b0);        check("R1/R10 vertical page", nt_page, 1);
    ppu_op(14'h2800, 1'b0);        check("R1/R10 vertical page low", nt_page, 0);
    ppu_op(14'h0000, 1'b1);        check("R9 chr_we mode 1", chr_we, 1);
  endtask

  task automatic t_mode1;
    cpu_op(16'h8000, 8'h5B, 1'b1);
    cpu_op(16'h8123, 8'h00, 1'b0); check("R5 bank from bits 6..2", prg_addr, 32'h18123);
    cpu_op(16'hC005, 8'h00, 1'b0); check("R5 fixed bank 7", prg_addr, 32'h1C005);
    ppu_op(14'h0456, 1'b0);        check("R5/R8 pattern bank 3", chr_addr, 32'h6456);
    cpu_op(16'h8000, 8'h18, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R5 bit6 clear bank 6", prg_addr, 32'h18000);
    cpu_op(16'h8000, 8'h5B, 1'b1);
  endtask

  task automatic t_mode0;
    cpu_op(16'h42FE, 8'h00, 1'b1);
    cpu_op(16'h9000, 8'hFD, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R4 bank from bits 2..0", prg_addr, 32'h14000);
    cpu_op(16'hE001, 8'h00, 1'b0); check("R4 fixed bank 7", prg_addr, 32'h1E001);
    ppu_op(14'h0010, 1'b1);        check("R8 pattern bank kept", chr_addr, 32'h6010);
    check("R9 chr_we mode 0", chr_we, 1);
    ppu_op(14'h2C00, 1'b0);        check("R2/R10 one-screen page 0", nt_page, 0);
  endtask

  task automatic t_mode23;
    cpu_op(16'h42FF, 8'h50, 1'b1);
    cpu_op(16'h8000, 8'h2A, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R6 mode2 low bank", prg_addr, 32'h28000);
    cpu_op(16'hC000, 8'h00, 1'b0); check("R6 mode2 fixed 15", prg_addr, 32'h3C000);
    ppu_op(14'h2800, 1'b0);        check("R10 horizontal high", nt_page, 1);
    ppu_op(14'h2400, 1'b0);        check("R10 horizontal low", nt_page, 0);
    cpu_op(16'h42FF, 8'h60, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R6 mode3 fixed 15 low", prg_addr, 32'h3C000);
    cpu_op(16'hC000, 8'h00, 1'b0); check("R6 mode3 switched high", prg_addr, 32'h28000);
  endtask

  task automatic t_mode47;
    cpu_op(16'h42FF, 8'h80, 1'b1);
    cpu_op(16'h8000, 8'h36, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R7 mode4 32K bank", prg_addr, 32'h18000);
    cpu_op(16'hFFFF, 8'h00, 1'b0); check("R7 mode4 top", prg_addr, 32'h1FFFF);
    ppu_op(14'h0000, 1'b1);        check("R8 mode4 pattern bank", chr_addr, 32'h4000);
    check("R9 chr_we blocked mode 4", chr_we, 0);
    cpu_op(16'h42FF, 8'hA0, 1'b1);
    cpu_op(16'h8000, 8'h01, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R7 mode5 bank 7", prg_addr, 32'h38000);
    ppu_op(14'h0000, 1'b0);        check("R8 mode5 pattern bank", chr_addr, 32'h2000);
    cpu_op(16'h42FF, 8'hC0, 1'b1);
    cpu_op(16'h8000, 8'h02, 1'b1);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R7 mode6 bank 3", prg_addr, 32'h18000);
    ppu_op(14'h0000, 1'b0);        check("R8 mode6 bit1 ignored", chr_addr, 32'h0000);
    cpu_op(16'h42FF, 8'hE0, 1'b1);
    cpu_op(16'h8000, 8'h03, 1'b1);
    cpu_op(16'hA000, 8'h00, 1'b0); check("R7 mode7 bank 3", prg_addr, 32'h1A000);
    ppu_op(14'h0000, 1'b0);        check("R8 mode7 pattern held", chr_addr, 32'h0000);
  endtask

  task automatic t_unprot;
    cpu_op(16'h42FD, 8'h20, 1'b1);
    cpu_op(16'h8004, 8'hFF, 1'b1);
    check("R3 prg_we unprotected", prg_we, 1);
    check("R3 write at current mapping", prg_addr, 32'h00004);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R3 latch ignored", prg_addr, 32'h00000);
    check("R3 prg_we drops", prg_we, 0);
    ppu_op(14'h0000, 1'b0);        check("R3 pattern bank ignored", chr_addr, 32'h0000);
    cpu_op(16'h42FF, 8'h20, 1'b1);
    cpu_op(16'h8000, 8'h08, 1'b1); check("R3 no prg_we protected", prg_we, 0);
    cpu_op(16'h8000, 8'h00, 1'b0); check("R3 latch loads protected", prg_addr, 32'h08000);
  endtask

  task automatic t_same_cycle;
    cpu_op(16'h8010, 8'h0C, 1'b1); check("R11 write uses old bank", prg_addr, 32'h08010);
    cpu_op(16'h8010, 8'h00, 1'b0); check("R11 next access new bank", prg_addr, 32'h0C010);
  endtask

  task automatic t_window;
    cpu_op(16'h42FB, 8'h00, 1'b1);
    cpu_op(16'h4300, 8'h00, 1'b1);
    cpu_op(16'h7FFF, 8'hFF, 1'b1);
    cpu_op(16'hC000, 8'h00, 1'b0); check("R2 outside window mode kept", prg_addr, 32'h1C000);
    cpu_op(16'h8010, 8'h00, 1'b0); check("R2 outside window latch kept", prg_addr, 32'h0C010);
    ppu_op(14'h2400, 1'b0);        check("R2 outside window mirroring", nt_page, 1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode1();
    t_mode0();
    t_mode23();
    t_mode47();
    t_unprot();
    t_same_cycle();
    t_window();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule